// File: doc/BRIEF.md
# Branch Condition Evaluation Unit

This block decides whether a conditional branch is taken. In the step where the register under test is on the shared data bus, the control asserts a strobe. A three-bit condition code then selects a test on that value, and the one-bit result is captured in an internal condition flag. Software never sees this flag. The test can be never, always, equal to zero, not zero, sign bit clear, or sign bit set.

In the following step the control puts the target register on the same bus and raises a load request. The new program counter is loaded from the bus only when the flag is set. Otherwise the current program counter passes through unchanged. The bus may carry the target either way, so only the load enable depends on the flag.

The condition code is the low three bits of the instruction word. The zero test is a wide NOR over every bus bit, built as a chunked reduction tree.

Top module: `branch_cond_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears the condition flag to 0.
- R2: With the strobe high, code 3'd0 stores 0 and code 3'd1 stores 1 in the flag at the next rising edge, whatever the bus value.
- R3: With the strobe high, code 3'd2 stores 1 exactly when all bus bits are zero, and code 3'd3 stores 1 exactly when at least one bus bit is one.
- R4: With the strobe high, code 3'd4 stores 1 exactly when bus bit 31 is 0, and code 3'd5 stores 1 exactly when bus bit 31 is 1.
- R5: With the strobe high, codes 3'd6 and 3'd7 store 0 in the flag.
- R6: With the strobe low, the flag keeps its value, whatever the code and bus inputs are.
- R7: When the load request is high and the flag is 1, `pc_load_o` is 1 and `pc_next_o` equals the bus value in that same cycle.
- R8: When the flag is 0, a load request is ignored: `pc_load_o` is 0 and `pc_next_o` equals `pc_cur_i`. When the load request is low, `pc_load_o` is 0 and `pc_next_o` equals `pc_cur_i`.
- R9: When the strobe and the load request are high in the same cycle, the load decision uses the flag value held before that edge, and the new result appears only after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_i | input | 32 | Shared data bus; carries the tested value or the branch target |
| cond_code_i | input | 3 | Condition selector (low three instruction bits) |
| cond_strobe_i | input | 1 | Capture the evaluated condition into the flag |
| pc_load_req_i | input | 1 | Request to load the program counter from the bus |
| pc_cur_i | input | 32 | Current program counter value |
| flag_o | output | 1 | Latched condition flag |
| pc_next_o | output | 32 | Next program counter value |
| pc_load_o | output | 1 | Program counter load enable |

## Verification
The bench looks at the values that decide each test. These are a zero bus against a bus with only bit 0 set, values with only the sign bit set or only the sign bit clear, and the two unused codes. A design that tested only a few bits for zero, read the wrong sign bit, or decoded codes 6 and 7 as always would leave the wrong flag after the strobe. It also raises the strobe and the load request in the same cycle. A design that passed the new flag straight through to the load enable would then branch one step early. Finally it holds the strobe low while the code and bus change, to catch a flag that is written on every edge.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        TEST_NEVER   = 3'd0,
        TEST_ALWAYS  = 3'd1,
        TEST_ZERO    = 3'd2,
        TEST_NONZERO = 3'd3,
        TEST_NONNEG  = 3'd4,
        TEST_NEG     = 3'd5
    } test_sel_e;

    typedef struct packed {
        logic flag;
    } flag_state_t;

endpackage

// File: rtl/bcu_zero_detect.sv
module bcu_zero_detect #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned CHUNK = 8
) (
    input  logic [WIDTH-1:0] value_i,
    output logic             is_zero_o
);
    localparam int unsigned NCHUNK = (WIDTH + CHUNK - 1) / CHUNK;
    localparam int unsigned PAD_W  = NCHUNK * CHUNK;

    logic [PAD_W-1:0]  padded;
    logic [NCHUNK-1:0] chunk_any;

    always_comb begin
        padded              = '0;
        padded[WIDTH-1:0]   = value_i;
    end

    for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
        assign chunk_any[g] = |padded[g*CHUNK +: CHUNK];
    end

    assign is_zero_o = ~(|chunk_any);

endmodule

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
    import bcu_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W,
    parameter int unsigned CHUNK = 8
) (
    input  logic [WIDTH-1:0]  value_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              result_o
);
    logic is_zero;
    logic sign_bit;

    bcu_zero_detect #(
        .WIDTH (WIDTH),
        .CHUNK (CHUNK)
    ) i_zero (
        .value_i   (value_i),
        .is_zero_o (is_zero)
    );

    assign sign_bit = value_i[WIDTH-1];

    always_comb begin
        unique case (code_i)
            TEST_NEVER:   result_o = 1'b0;
            TEST_ALWAYS:  result_o = 1'b1;
            TEST_ZERO:    result_o = is_zero;
            TEST_NONZERO: result_o = ~is_zero;
            TEST_NONNEG:  result_o = ~sign_bit;
            TEST_NEG:     result_o = sign_bit;
            default:      result_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcu_flag_reg.sv
module bcu_flag_reg
    import bcu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    input  logic result_i,
    output logic flag_o
);
    flag_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (strobe_i) begin
            state_d.flag = result_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag_o = state_q.flag;

    AST_FLAG_CLEARED: assert property (@(posedge clk) rst |=> !flag_o); // R1
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> $stable(flag_o)); // R6
    AST_FLAG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        strobe_i |=> flag_o == $past(result_i)); // R2

endmodule

// File: rtl/bcu_pc_select.sv
module bcu_pc_select #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flag_i,
    input  logic             load_req_i,
    input  logic [WIDTH-1:0] target_i,
    input  logic [WIDTH-1:0] pc_cur_i,
    output logic [WIDTH-1:0] pc_next_o,
    output logic             pc_load_o
);
    always_comb begin
        pc_load_o = load_req_i & flag_i;
        pc_next_o = pc_load_o ? target_i : pc_cur_i;
    end

    AST_LOAD_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        !flag_i |-> (!pc_load_o && pc_next_o == pc_cur_i)); // R8
    AST_LOAD_TAKES_BUS: assert property (@(posedge clk) disable iff (rst)
        (flag_i && load_req_i) |-> (pc_load_o && pc_next_o == target_i)); // R7

endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import bcu_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W,
    parameter int unsigned ZERO_CHUNK = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIDTH-1:0]  bus_i,
    input  logic [CODE_W-1:0] cond_code_i,
    input  logic              cond_strobe_i,
    input  logic              pc_load_req_i,
    input  logic [WIDTH-1:0]  pc_cur_i,
    output logic              flag_o,
    output logic [WIDTH-1:0]  pc_next_o,
    output logic              pc_load_o
);
    logic cond_result;

    bcu_cond_eval #(
        .WIDTH (WIDTH),
        .CHUNK (ZERO_CHUNK)
    ) i_eval (
        .value_i  (bus_i),
        .code_i   (cond_code_i),
        .result_o (cond_result)
    );

    bcu_flag_reg i_flag (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (cond_strobe_i),
        .result_i (cond_result),
        .flag_o   (flag_o)
    );

    bcu_pc_select #(
        .WIDTH (WIDTH)
    ) i_pcsel (
        .clk        (clk),
        .rst        (rst),
        .flag_i     (flag_o),
        .load_req_i (pc_load_req_i),
        .target_i   (bus_i),
        .pc_cur_i   (pc_cur_i),
        .pc_next_o  (pc_next_o),
        .pc_load_o  (pc_load_o)
    );

    AST_NEVER_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cond_strobe_i && cond_code_i == 3'd0) |=> !flag_o); // R2
    AST_ALWAYS_SETS: assert property (@(posedge clk) disable iff (rst)
        (cond_strobe_i && cond_code_i == 3'd1) |=> flag_o); // R2
    AST_ZERO_TEST: assert property (@(posedge clk) disable iff (rst)
        (cond_strobe_i && cond_code_i == 3'd2) |=> flag_o == ($past(bus_i) == '0)); // R3
    AST_SIGN_TEST: assert property (@(posedge clk) disable iff (rst)
        (cond_strobe_i && cond_code_i == 3'd5) |=> flag_o == $past(bus_i[WIDTH-1])); // R4
    AST_UNUSED_CODES: assert property (@(posedge clk) disable iff (rst)
        (cond_strobe_i && cond_code_i[2:1] == 2'b11) |=> !flag_o); // R5
    AST_LOAD_OLD_FLAG: assert property (@(posedge clk) disable iff (rst)
        (cond_strobe_i && pc_load_req_i) |-> (pc_load_o == flag_o)); // R9

endmodule

// File: tb/test_branch_cond_unit.sv
module test_branch_cond_unit;
    localparam time CLK_PERIOD = 10ns;
    localparam int NVEC = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] bus_i;
    logic [2:0]  cond_code_i;
    logic        cond_strobe_i;
    logic        pc_load_req_i;
    logic [31:0] pc_cur_i;
    logic        flag_o;
    logic [31:0] pc_next_o;
    logic        pc_load_o;

    int checks = 0;
    int errors = 0;

    // {code, tested value, expected flag}
    localparam logic [35:0] VEC [NVEC] = '{
        {3'd0, 32'hFFFF_FFFF, 1'b0},
        {3'd1, 32'h0000_0000, 1'b1},
        {3'd2, 32'h0000_0000, 1'b1},
        {3'd2, 32'h0000_0001, 1'b0},
        {3'd2, 32'h8000_0000, 1'b0},
        {3'd3, 32'h0000_0000, 1'b0},
        {3'd3, 32'h0001_0000, 1'b1},
        {3'd4, 32'h7FFF_FFFF, 1'b1},
        {3'd4, 32'h8000_0000, 1'b0},
        {3'd4, 32'h0000_0000, 1'b1},
        {3'd5, 32'h8000_0000, 1'b1},
        {3'd5, 32'h7FFF_FFFF, 1'b0},
        {3'd6, 32'h0000_0000, 1'b0},
        {3'd6, 32'h8000_0000, 1'b0},
        {3'd7, 32'hFFFF_FFFF, 1'b0},
        {3'd1, 32'h1234_5678, 1'b1}
    };

    branch_cond_unit i_branch_cond_unit (
        .clk           (clk),
        .rst           (rst),
        .bus_i         (bus_i),
        .cond_code_i   (cond_code_i),
        .cond_strobe_i (cond_strobe_i),
        .pc_load_req_i (pc_load_req_i),
        .pc_cur_i      (pc_cur_i),
        .flag_o        (flag_o),
        .pc_next_o     (pc_next_o),
        .pc_load_o     (pc_load_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string req_of(input logic [2:0] code);
        if (code <= 3'd1) return "R2";
        if (code <= 3'd3) return "R3";
        if (code <= 3'd5) return "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at the falling edge, then let a rising edge pass and sample 1 ns later
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic s, input logic [2:0] c, input logic [31:0] b,
                         input logic lr, input logic [31:0] pc);
        @(negedge clk);
        cond_strobe_i = s;
        cond_code_i   = c;
        bus_i         = b;
        pc_load_req_i = lr;
        pc_cur_i      = pc;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cond_strobe_i = 1'b0;
        cond_code_i = 3'd0;
        bus_i = '0;
        pc_load_req_i = 1'b0;
        pc_cur_i = 32'h40;
        step();
        step();
        check("R1 reset flag", {31'd0, flag_o}, 32'd0);
        check("R8 reset load", {31'd0, pc_load_o}, 32'd0);
        check("R8 reset pc", pc_next_o, 32'h40);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic [2:0]  c;
            logic [31:0] b;
            logic        e;
            logic [31:0] tgt;
            logic [31:0] pc;
            c = VEC[i][35:33];
            b = VEC[i][32:1];
            e = VEC[i][0];
            tgt = 32'hA000_0000 + 32'(i) * 4;
            pc  = 32'h0000_0100 + 32'(i);
            drive(1'b1, c, b, 1'b0, pc);
            step();
            check(req_of(c), {31'd0, flag_o}, {31'd0, e});
            drive(1'b0, 3'd0, tgt, 1'b1, pc);
            #1;
            check(e ? "R7 load" : "R8 load", {31'd0, pc_load_o}, {31'd0, e});
            check(e ? "R7 pc" : "R8 pc", pc_next_o, e ? tgt : pc);
            drive(1'b0, 3'd0, tgt, 1'b0, pc);
            #1;
            check("R8 no request", pc_next_o, pc);
        end

        // R6: flag holds while strobe is low
        drive(1'b1, 3'd1, 32'h0, 1'b0, 32'h200);
        step();
        drive(1'b0, 3'd0, 32'hFFFF_FFFF, 1'b0, 32'h200);
        step();
        drive(1'b0, 3'd6, 32'h0, 1'b0, 32'h200);
        step();
        check("R6 hold high", {31'd0, flag_o}, 32'd1);
        drive(1'b1, 3'd0, 32'h0, 1'b0, 32'h200);
        step();
        drive(1'b0, 3'd1, 32'h0, 1'b0, 32'h200);
        step();
        check("R6 hold low", {31'd0, flag_o}, 32'd0);

        // R9: strobe and load in one cycle use the old flag
        drive(1'b1, 3'd1, 32'h0, 1'b0, 32'h300);
        step();
        drive(1'b1, 3'd0, 32'hB000_0000, 1'b1, 32'h300);
        #1;
        check("R9 old flag set load", {31'd0, pc_load_o}, 32'd1);
        check("R9 old flag set pc", pc_next_o, 32'hB000_0000);
        step();
        check("R9 flag after edge", {31'd0, flag_o}, 32'd0);
        drive(1'b1, 3'd1, 32'hC000_0000, 1'b1, 32'h304);
        #1;
        check("R9 old flag clear load", {31'd0, pc_load_o}, 32'd0);
        check("R9 old flag clear pc", pc_next_o, 32'h304);
        step();
        check("R9 flag set after edge", {31'd0, flag_o}, 32'd1);

        // R1: reset clears a set flag, even with a strobe present
        drive(1'b1, 3'd1, 32'h0, 1'b0, 32'h400);
        rst = 1'b1;
        step();
        check("R1 mid reset", {31'd0, flag_o}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        cond_strobe_i = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule